// File: doc/BRIEF.md
# Loopback-Capable Nibble Serializer/Deserializer

This block models the digital datapath of a 4-bit serial link endpoint. On the receive side, a serial bit stream qualified by a bit-rate enable (standing in for the recovered clock) is packed, most significant bit first, into 4-bit words. Each word is presented with a single-cycle strobe that marks one word per four received bits. On the transmit side, 4-bit words enter an 8-entry queue. A serializer drains the queue one bit per transmit bit enable, most significant bit first, and a retiming flop drives the serial output.

Two remote loopback controls change where the transmit chain takes its data. Serial loopback sends the incoming serial bit straight to the retiming flop, which is then clocked by the receive bit enable. Parallel loopback feeds the transmit queue with the deserialized words in place of the local transmit words. In both modes the receive word output keeps running. A queue flush input clears the transmit queue, its error flags and the serializer state. It is meant to be pulsed after every change of parallel loopback. All ideal clocks are expressed as enables on one system clock, and reset is synchronous and active high.

Top module: `loopback_serdes`

## Requirements
- R1: After reset, tx_bit, rx_word_stb, txq_ovf and txq_unf are all 0.
- R2: The receiver shifts rx_bit into a word, first bit landing in bit 3, on each cycle with rx_bit_en high. In the cycle after the clock edge that takes the fourth bit, rx_word holds the new word and rx_word_stb is high for exactly one cycle.
- R3: The serializer sends bit 3 of each queued word first and bit 0 last. It advances one bit per clock edge with tx_bit_en high, and each bit appears on tx_bit in the cycle after that edge.
- R4: With both loopback controls low, each cycle with tx_word_vld high writes tx_word into the queue, and the words are sent in the order they were written.
- R5: With loop_ser high, every edge with rx_bit_en high loads rx_bit into the output flop, so tx_bit equals the previous rx_bit. tx_bit_en then has no effect.
- R6: rx_word and rx_word_stb behave as in R2 whatever the loopback controls are set to.
- R7: With loop_par high and loop_ser low, the queue is written with rx_word on each rx_word_stb. tx_word_vld and tx_word are ignored, and the looped words leave on tx_bit as in R3.
- R8: With both controls high, tx_bit follows rx_bit as in R5.
- R9: When a new word is due (at a word boundary) and the queue is empty, the serializer drives 0 for that bit time.
- R10: A cycle with txq_flush high empties the queue, clears txq_ovf and txq_unf, and abandons any partly sent word.
- R11: The queue holds 8 words. A write while it is full is dropped and sets txq_ovf, which stays set until a flush.
- R12: txq_unf is set, and stays set until a flush, when a word is due, the queue is empty, and at least one word has been taken since the last flush or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_en | input | 1 | Receive bit-rate enable (recovered clock) |
| rx_word | output | 4 | Deserialized receive word |
| rx_word_stb | output | 1 | One-cycle qualifier for rx_word |
| tx_word | input | 4 | Local transmit word |
| tx_word_vld | input | 1 | Write tx_word into the transmit queue |
| tx_bit_en | input | 1 | Transmit bit-rate enable |
| tx_bit | output | 1 | Retimed serial transmit bit |
| loop_ser | input | 1 | Serial remote loopback select |
| loop_par | input | 1 | Parallel remote loopback select |
| txq_flush | input | 1 | Transmit queue flush |
| txq_ovf | output | 1 | Sticky queue overflow flag |
| txq_unf | output | 1 | Sticky queue underflow flag |

## Verification
The bench targets the points where the two loopback paths and the queue meet. It checks that with both controls high the serial path wins; a design with the priority reversed would emit queued words instead of the live bit stream. In parallel loopback it holds tx_word_vld high throughout, so a design that left the local write path open would send 0xF words between the looped ones. It sends a ninth word into a full queue, flushes a queue that still holds words, and drains past the last word. Each of these catches a specific fault: a 9-entry queue, a flush that keeps stale data, or an underflow flag that fires while idle after a flush.

// File: rtl/loopback_serdes_pkg.sv
package loopback_serdes_pkg;
    localparam int WORD_W    = 4;
    localparam int TXQ_DEPTH = 8;
    localparam int BITCNT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_PAR_LOOP = 2'b01,
        MODE_SER_LOOP = 2'b10,
        MODE_BOTH     = 2'b11
    } loop_mode_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } txq_flags_t;

    function automatic word_t shift_in_lsb(word_t w, logic b);
        return {w[WORD_W-2:0], b};
    endfunction

    function automatic loop_mode_e decode_mode(logic ser, logic par);
        return loop_mode_e'({ser, par});
    endfunction
endpackage

// File: rtl/lbsd_rx_deser.sv
module lbsd_rx_deser
    import loopback_serdes_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  bit_in,
    output word_t word_out,
    output logic  word_stb
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(WORD_W - 1);

    logic [BITCNT_W-1:0] cnt;
    word_t               shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            shreg    <= '0;
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bit_en) begin
                shreg <= shift_in_lsb(shreg, bit_in);
                if (cnt == LAST_BIT) begin
                    cnt      <= '0;
                    word_out <= shift_in_lsb(shreg, bit_in);
                    word_stb <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    // R2
    stb_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(word_stb) |-> $past(bit_en));
endmodule

// File: rtl/lbsd_tx_fifo.sv
module lbsd_tx_fifo
    import loopback_serdes_pkg::*;
#(
    parameter int DEPTH = TXQ_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wr,
    input  word_t wdata,
    input  logic  rd,
    output word_t rdata,
    output logic  empty,
    output logic  ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT  = (AW+1)'(DEPTH);

    word_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [AW:0]    count;
    logic           full, do_wr, do_rd;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_wr = wr && !full && !clr;
    assign do_rd = rd && !empty && !clr;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == LAST_SLOT) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST_SLOT) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr && full) ovf <= 1'b1;
        end
    end

    // R11
    fifo_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (empty && !ovf));
endmodule

// File: rtl/lbsd_tx_ser.sv
module lbsd_tx_ser
    import loopback_serdes_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  bit_en,
    input  logic  q_empty,
    input  word_t q_data,
    output logic  pop,
    output logic  bit_now,
    output logic  word_edge,
    output logic  unf
);
    logic [BITCNT_W-1:0] left;
    word_t               shreg;
    logic                primed;

    assign word_edge = (left == '0);
    assign pop       = bit_en && word_edge && !q_empty && !clr;
    assign bit_now   = word_edge ? (!q_empty && q_data[WORD_W-1]) : shreg[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            left   <= '0;
            shreg  <= '0;
            primed <= 1'b0;
            unf    <= 1'b0;
        end else if (bit_en) begin
            if (word_edge) begin
                if (!q_empty) begin
                    shreg  <= q_data << 1;
                    left   <= BITCNT_W'(WORD_W - 1);
                    primed <= 1'b1;
                end else if (primed) begin
                    unf <= 1'b1;
                end
            end else begin
                shreg <= shreg << 1;
                left  <= left - 1'b1;
            end
        end
    end

    // R12
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unf && !clr) |=> unf);

    // R10
    flush_aligns_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (word_edge && !unf));
endmodule

// File: rtl/loopback_serdes.sv
module loopback_serdes
    import loopback_serdes_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              rx_bit_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_word_vld,
    input  logic              tx_bit_en,
    output logic              tx_bit,
    input  logic              loop_ser,
    input  logic              loop_par,
    input  logic              txq_flush,
    output logic              txq_ovf,
    output logic              txq_unf
);
    loop_mode_e mode;
    txq_flags_t flags;
    word_t      q_wdata, q_rdata;
    logic       q_wr, q_empty, q_pop;
    logic       ser_en, ser_bit, ser_edge;
    logic       par_sel, ser_sel;

    assign mode    = decode_mode(loop_ser, loop_par);
    assign ser_sel = (mode == MODE_SER_LOOP) || (mode == MODE_BOTH);
    assign par_sel = (mode == MODE_PAR_LOOP) || (mode == MODE_BOTH);

    lbsd_rx_deser u_deser (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (rx_bit_en),
        .bit_in   (rx_bit),
        .word_out (rx_word),
        .word_stb (rx_word_stb)
    );

    assign q_wr    = par_sel ? rx_word_stb : tx_word_vld;
    assign q_wdata = par_sel ? rx_word     : tx_word;

    lbsd_tx_fifo #(.DEPTH(TXQ_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (txq_flush),
        .wr    (q_wr),
        .wdata (q_wdata),
        .rd    (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .ovf   (flags.ovf)
    );

    assign ser_en = tx_bit_en && !ser_sel;

    lbsd_tx_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .clr       (txq_flush),
        .bit_en    (ser_en),
        .q_empty   (q_empty),
        .q_data    (q_rdata),
        .pop       (q_pop),
        .bit_now   (ser_bit),
        .word_edge (ser_edge),
        .unf       (flags.unf)
    );

    always_ff @(posedge clk) begin
        if (rst)                          tx_bit <= 1'b0;
        else if (ser_sel && rx_bit_en)    tx_bit <= rx_bit;
        else if (!ser_sel && txq_flush)   tx_bit <= 1'b0;
        else if (ser_en)                  tx_bit <= ser_bit;
    end

    assign txq_ovf = flags.ovf;
    assign txq_unf = flags.unf;

    // R5
    ser_loop_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (loop_ser && rx_bit_en) |=> (tx_bit == $past(rx_bit)));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!loop_ser && !txq_flush && tx_bit_en && q_empty && ser_edge) |=> !tx_bit);

    // R7
    par_loop_source_chk: assert property (@(posedge clk) disable iff (rst)
        (loop_par && !rx_word_stb) |-> !q_wr);
endmodule

// File: tb/loopback_serdes_bench.sv
module loopback_serdes_bench;
    import loopback_serdes_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  rx_bit = 1'b0, rx_bit_en = 1'b0;
    word_t rx_word;
    logic  rx_word_stb;
    word_t tx_word = '0;
    logic  tx_word_vld = 1'b0, tx_bit_en = 1'b0;
    logic  tx_bit;
    logic  loop_ser = 1'b0, loop_par = 1'b0, txq_flush = 1'b0;
    logic  txq_ovf, txq_unf;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic en_q = 1'b0;

    word_t exp_rx[$];
    logic  exp_tx[$];

    always #4 clk = ~clk;

    loopback_serdes u_loopback_serdes (
        .clk(clk), .rst(rst),
        .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .rx_word(rx_word), .rx_word_stb(rx_word_stb),
        .tx_word(tx_word), .tx_word_vld(tx_word_vld),
        .tx_bit_en(tx_bit_en), .tx_bit(tx_bit),
        .loop_ser(loop_ser), .loop_par(loop_par), .txq_flush(txq_flush),
        .txq_ovf(txq_ovf), .txq_unf(txq_unf)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // bit-clock seen by the retimer at the last edge
    always @(posedge clk) en_q <= loop_ser ? rx_bit_en : tx_bit_en;

    // monitor: transmit bits (R3, R5, R8, R9)
    always @(negedge clk) begin
        if (!rst && en_q && exp_tx.size() > 0) begin
            logic e;
            e = exp_tx.pop_front();
            chk(tx_bit == e, "R3/R5/R9 tx bit", int'(tx_bit), int'(e));
        end
    end

    // monitor: receive words (R2, R6)
    always @(negedge clk) begin
        if (!rst && rx_word_stb) begin
            if (exp_rx.size() == 0) begin
                chk(1'b0, "R2 unexpected rx word", int'(rx_word), -1);
            end else begin
                word_t w;
                w = exp_rx.pop_front();
                chk(rx_word == w, "R2/R6 rx word", int'(rx_word), int'(w));
            end
        end
    end

    task automatic send_rx(word_t w);
        exp_rx.push_back(w);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            rx_bit    = w[i];
            rx_bit_en = 1'b1;
            if (loop_ser) exp_tx.push_back(w[i]);
            tick();
        end
        rx_bit_en = 1'b0;
    endtask

    task automatic push_word_bits(word_t w);
        for (int i = WORD_W - 1; i >= 0; i--) exp_tx.push_back(w[i]);
    endtask

    task automatic write_tx(word_t w);
        tx_word = w;
        tx_word_vld = 1'b1;
        tick();
        tx_word_vld = 1'b0;
    endtask

    task automatic run_tx(int n);
        for (int i = 0; i < n; i++) begin
            tx_bit_en = 1'b1;
            tick();
        end
        tx_bit_en = 1'b0;
        tick();
    endtask

    task automatic flush();
        txq_flush = 1'b1;
        tick();
        txq_flush = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(tx_bit == 1'b0, "R1 tx_bit", int'(tx_bit), 0);
        chk(rx_word_stb == 1'b0, "R1 rx_word_stb", int'(rx_word_stb), 0);
        chk(txq_ovf == 1'b0 && txq_unf == 1'b0, "R1 flags", int'({txq_ovf, txq_unf}), 0);

        // R2 receive packing
        send_rx(4'hA); send_rx(4'h5); send_rx(4'h0); send_rx(4'hF);
        tick();

        // R3 R4 normal transmit, then R9 R12 drain past the end
        flush();
        write_tx(4'hA); write_tx(4'h3); write_tx(4'hC);
        push_word_bits(4'hA); push_word_bits(4'h3); push_word_bits(4'hC);
        run_tx(12);
        chk(txq_unf == 1'b0, "R12 no unf while data", int'(txq_unf), 0);
        push_word_bits(4'h0);
        run_tx(4);
        chk(txq_unf == 1'b1, "R12 unf after drain", int'(txq_unf), 1);
        flush();
        chk(txq_unf == 1'b0, "R10 flush clears unf", int'(txq_unf), 0);

        // R10 flush discards queued words and unarms underflow
        write_tx(4'h7); write_tx(4'hE);
        flush();
        push_word_bits(4'h0); push_word_bits(4'h0);
        run_tx(8);
        chk(txq_unf == 1'b0, "R10 unf after flush idle", int'(txq_unf), 0);

        // R11 overflow: ninth write dropped
        for (int i = 1; i <= 9; i++) write_tx(word_t'(i));
        chk(txq_ovf == 1'b1, "R11 ovf set", int'(txq_ovf), 1);
        for (int i = 1; i <= 8; i++) push_word_bits(word_t'(i));
        run_tx(32);
        push_word_bits(4'h0);
        run_tx(4);
        chk(txq_ovf == 1'b1, "R11 ovf sticky", int'(txq_ovf), 1);
        flush();
        chk(txq_ovf == 1'b0, "R10 flush clears ovf", int'(txq_ovf), 0);

        // R5 R6 serial loopback, tx_bit_en toggling is ignored
        loop_ser = 1'b1;
        tx_bit_en = 1'b1;
        send_rx(4'h9);
        tick();
        send_rx(4'h6);
        send_rx(4'h3);
        tx_bit_en = 1'b0;
        tick();
        loop_ser = 1'b0;

        // R7 parallel loopback, local writes held active but ignored
        loop_par = 1'b1;
        flush();
        tx_word = 4'hF;
        tx_word_vld = 1'b1;
        send_rx(4'h9);
        send_rx(4'h6);
        tick();
        tx_word_vld = 1'b0;
        push_word_bits(4'h9); push_word_bits(4'h6); push_word_bits(4'h0);
        run_tx(12);
        chk(txq_unf == 1'b1, "R7 only looped words queued", int'(txq_unf), 1);

        // R8 both loopbacks: serial wins on the output
        loop_ser = 1'b1;
        flush();
        send_rx(4'hB);
        send_rx(4'h4);
        tick();
        loop_ser = 1'b0;
        loop_par = 1'b0;
        flush();
        tick();

        chk(exp_rx.size() == 0, "R2/R6 all rx words seen", exp_rx.size(), 0);
        chk(exp_tx.size() == 0, "R3 all tx bits seen", exp_tx.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule